// File: doc/BRIEF.md
# MDIO Station Management Master

This block is a register-driven management master for clause-22 style PHY access over a two-wire MDC/MDIO link. Software fills in a control word holding a PHY address, a register address, a direction flag and a clock-range code. For a write it first loads a 16-bit data word. It then sets the control word's busy flag to launch one 64-bit management frame. The flag stays set for the whole frame and the hardware clears it when the frame ends. On a read, the sixteen bits returned by the PHY land in the data word in the same cycle.

MDC is derived from the system clock by a divider picked with a 2-bit code. Software must pick the code so that MDC stays at or below 2.5 MHz for its bus clock. The code is not monotonic in the ratio: code 0 divides by 42, code 1 by 62, code 2 by 16 and code 3 by 26. The MDIO pad is reached through separate output, output-enable and input signals, and the tri-state buffer sits outside the block.

Software polls the busy flag before it touches either register. While a frame is running, every register write is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `ctrl_rdata` and `data_rdata` read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to the control word (`reg_sel`=0) with bit 0 set while busy is 0 sets busy (bit 0 of `ctrl_rdata`) from the next cycle. Busy stays 1 for exactly 64×D clock cycles, where D is the selected divisor, and then clears by itself.
- R3: Control bits [3:2] select D: 0→42, 1→62, 2→16, 3→26. During a frame, MDC has a period of D clock cycles, with D/2 cycles low and then D/2 cycles high. Exactly 64 rising edges occur per frame.
- R4: When no frame is active, `mdc` and `mdio_oe` are both low.
- R5: Control word layout: bit 1 is the direction (1 = write, 0 = read), [8:4] is the register address and [13:9] is the PHY address. The frame, sampled at the rising edges of MDC and sent MSB first, is 32 ones, then 01, then the opcode (01 write, 10 read), the PHY address, the register address, the turnaround and 16 data bits. A write drives turnaround 10 and then the data word.
- R6: On a read, `mdio_oe` is high for the first 46 bits and low for the turnaround and the 16 data bits. On a write it is high for all 64 bits.
- R7: On a read, the 16 bits sampled from `mdio_in` on MDC rising edges 49 to 64, MSB first, are written to `data_rdata` on the clock edge where busy clears.
- R8: While busy is 1, writes to the data word and to the control word are ignored. Addresses, direction, clock range and data keep their values.
- R9: Setting bit 0 of the control word while busy is already 1 has no effect: the frame is neither extended nor restarted.
- R10: `mdio_out` changes only together with a falling MDC edge, or when a frame starts. It holds steady through every high phase of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = data word |
| reg_wdata | input | 16 | Register write value |
| ctrl_rdata | output | 16 | Control word readback, busy in bit 0 |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
The start edge is the clock edge that samples the control write. The first MDC rise comes D/2 cycles after it, and every later rise comes D cycles after the one before. Busy and the read data both change on the start edge plus 64×D, so the bench reads them on the falling clock edges just before and just after that edge. Frame bits and output enables are recorded at each MDC rise and compared against a frame the bench builds itself. The held MDIO level is compared on every falling clock edge inside a high phase. The PHY model changes `mdio_in` only after each rise, so every bit sampled by the design is settled.

// File: rtl/mdio_pkg.sv
// Shared types and constants for the MDIO management master.
// Assumes clause-22 framing: 64 bits per frame, 5-bit addresses.
package mdio_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int FRAME_W  = 64;
    localparam int IDX_W    = $clog2(FRAME_W);

    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(46);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(48);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              wr;
    } cmd_t;

    // Assemble the 64-bit serial frame, MSB sent first.
    function automatic logic [FRAME_W-1:0] build_frame(cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] pay;
        op  = c.wr ? 2'b01 : 2'b10;
        ta  = c.wr ? 2'b10 : 2'b00;
        pay = c.wr ? d : '0;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, pay};
    endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: divides clk by a divisor picked with a 2-bit code.
// Each MDC period is low for half the divisor and then high for the
// other half. Rise and fall strobes come out one cycle ahead of the
// MDC register. Assumes even divisors; MDC is held low while idle.
module mdio_clk_gen #(
    parameter int DIV0 = 42,
    parameter int DIV1 = 62,
    parameter int DIV2 = 16,
    parameter int DIV3 = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] sel,
    output logic       mdc,
    output logic       rise_tick,
    output logic       fall_tick
);
    localparam int DMAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int DMAX23 = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
    localparam int CW     = $clog2(DMAX + 1);
    localparam int DIVS [4] = '{DIV0, DIV1, DIV2, DIV3};

    logic [CW-1:0] div_tab [4];
    logic [CW-1:0] div_n;
    logic [CW-1:0] half_n;
    logic [CW-1:0] cnt;

    // Build the divisor table from the parameters.
    for (genvar g = 0; g < 4; g++) begin : g_div
        assign div_tab[g] = CW'(DIVS[g]);
    end

    // Look up the active divisor and its half.
    always_comb begin
        div_n  = div_tab[sel];
        half_n = div_n >> 1;
    end

    assign rise_tick = active && (cnt == half_n - CW'(1));
    assign fall_tick = active && (cnt == div_n - CW'(1));

    // Phase counter: runs only while a frame is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (fall_tick)    cnt <= '0;
        else                   cnt <= cnt + CW'(1);
    end

    // MDC register: set on the rise strobe, cleared on the fall strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) mdc <= 1'b0;
        else if (rise_tick)    mdc <= 1'b1;
        else if (fall_tick)    mdc <= 1'b0;
    end

    // R4
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdc);
    // R3
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(active) && active);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: shifts one 64-bit management frame out on MDIO.
// The next bit goes out on each fall strobe. Read data is sampled on
// each rise strobe during the data phase. A done pulse coincides with
// the final MDC fall. Assumes start only arrives while idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdc_i,
    input  logic              mdio_in,
    output logic              active,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic               wr_q;
    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] tx_sr;
    logic [DATA_W-1:0]  rx_sr;

    assign done     = active && fall_tick && (idx == IDX_LAST);
    assign rd_valid = done && !wr_q;
    assign rd_data  = rx_sr;
    assign mdio_out = active && tx_sr[FRAME_W-1];
    assign mdio_oe  = active && (wr_q || (idx < IDX_TA));

    // Frame sequencing: load on start, shift on fall, sample on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            wr_q   <= 1'b0;
            idx    <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                wr_q   <= cmd.wr;
                idx    <= '0;
                tx_sr  <= build_frame(cmd, wdata);
            end
        end else begin
            if (rise_tick && !wr_q && (idx >= IDX_DATA))
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_in};
            if (fall_tick) begin
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                idx   <= idx + IDX_W'(1);
                if (idx == IDX_LAST) active <= 1'b0;
            end
        end
    end

    // R10
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_out) && $past(active)) |-> $fell(mdc_i));
    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdio_oe) && active) |-> (!wr_q && !mdc_i));
endmodule

// File: rtl/mdio_regs.sv
// Software-visible registers: a control word with a self-clearing busy
// flag, and a data word. All writes are dropped while busy is set.
// Control layout: [0] busy, [1] write, [3:2] clock range,
// [8:4] register address, [13:9] PHY address.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output cmd_t              cmd,
    output logic [1:0]        clk_sel,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] data_q
);
    logic              busy;
    logic              wr_q;
    logic [1:0]        csel_q;
    logic [ADDR_W-1:0] reg_q;
    logic [ADDR_W-1:0] phy_q;
    logic              ctrl_wr;

    assign ctrl_wr   = wr_en && !sel;
    assign start     = ctrl_wr && wdata[0] && !busy;
    assign cmd.wr    = wdata[1];
    assign cmd.regad = wdata[8:4];
    assign cmd.phy   = wdata[13:9];
    assign clk_sel   = csel_q;
    assign ctrl_q    = {2'b00, phy_q, reg_q, csel_q, wr_q, busy};

    // Control word: loaded only while idle; busy clears on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            wr_q   <= 1'b0;
            csel_q <= 2'b00;
            reg_q  <= '0;
            phy_q  <= '0;
        end else if (ctrl_wr && !busy) begin
            busy   <= wdata[0];
            wr_q   <= wdata[1];
            csel_q <= wdata[3:2];
            reg_q  <= wdata[8:4];
            phy_q  <= wdata[13:9];
        end else if (done) begin
            busy   <= 1'b0;
        end
    end

    // Data word: read result wins; software writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (rd_valid)             data_q <= rd_data;
        else if (wr_en && sel && !busy) data_q <= wdata;
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R8
    ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q[13:1]));
    // R8
    data_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_valid) |=> $stable(data_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top of the MDIO management master: register file, MDC generator and
// frame engine. The MDIO tri-state pad sits outside this block.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV0 = 42,
    parameter int DIV1 = 62,
    parameter int DIV2 = 16,
    parameter int DIV3 = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] ctrl_rdata,
    output logic [15:0] data_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic              start;
    cmd_t              cmd;
    logic [1:0]        clk_sel;
    logic              active;
    logic              rise_tick;
    logic              fall_tick;
    logic              done;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;

    mdio_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .done     (done),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .start    (start),
        .cmd      (cmd),
        .clk_sel  (clk_sel),
        .ctrl_q   (ctrl_rdata),
        .data_q   (data_rdata)
    );

    mdio_clk_gen #(
        .DIV0 (DIV0),
        .DIV1 (DIV1),
        .DIV2 (DIV2),
        .DIV3 (DIV3)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sel       (clk_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .wdata     (data_rdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdc_i     (mdc),
        .mdio_in   (mdio_in),
        .active    (active),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R7
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (data_rdata == $past(rd_data)) && !ctrl_rdata[0]);
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a PHY model answers reads, and monitors record
// each frame at the MDC rising edges.
module mdio_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_rdata, data_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int n_chk = 0;
    int n_bad = 0;

    // Frame monitor state
    int      rise_cnt = 0;
    int      cur_div = 42;
    int      bad_period = 0;
    int      hold_viol = 0;
    int      idle_viol = 0;
    time     last_rise = 0;
    logic    cap_out [64];
    logic    cap_oe  [64];
    logic    held = 1'b0;
    logic [15:0] phy_word = '0;

    always #10 clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: read data bits follow the rising-edge count.
    assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? phy_word[63 - rise_cnt] : 1'b1;

    always @(posedge mdc) begin
        if (rise_cnt > 0 && rise_cnt < 64 && ($time - last_rise) != cur_div * 20)
            bad_period++;
        last_rise = $time;
        held = mdio_out;
        if (rise_cnt < 64) begin
            cap_out[rise_cnt] = mdio_out;
            cap_oe[rise_cnt]  = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge clk) begin
        if (mdc && mdio_out !== held) hold_viol++;
        if (rst_n && !ctrl_rdata[0] && (mdc || mdio_oe)) idle_viol++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'd0: return 42;
            2'd1: return 62;
            2'd2: return 16;
            default: return 26;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
                (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
    endfunction

    function automatic logic [15:0] ctrl_word(input bit go, input bit wr, input logic [1:0] cs,
                                              input logic [4:0] ra, input logic [4:0] phy);
        return {2'b00, phy, ra, cs, wr, go};
    endfunction

    task automatic write_reg(input logic s, input logic [15:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // One frame plus optional writes while busy; k counts negedges since start.
    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [1:0] cs, input logic [15:0] d, input bit poke);
        int k;
        int tot;
        int miss;
        logic [63:0] ef;
        logic [15:0] prev_data;
        logic [15:0] exp_data;
        if (wr) write_reg(1'b1, d);
        prev_data = data_rdata;
        phy_word  = d;
        cur_div   = div_of(cs);
        tot       = 64 * cur_div;
        rise_cnt  = 0; bad_period = 0; hold_viol = 0;
        write_reg(1'b0, ctrl_word(1'b1, wr, cs, ra, phy));
        k = 0;
        // R2: busy visible right after the start edge
        check(ctrl_rdata[0] == 1'b1, "R2 busy set", ctrl_rdata[0], 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            k += 6;
            write_reg(1'b1, ~d);
            k += 2;
            write_reg(1'b0, ctrl_word(1'b1, ~wr, ~cs, ~ra, ~phy));
            k += 2;
            // R8: fields and data frozen during busy
            check(ctrl_rdata == ctrl_word(1'b1, wr, cs, ra, phy), "R8 ctrl frozen",
                  ctrl_rdata, ctrl_word(1'b1, wr, cs, ra, phy));
            check(data_rdata == prev_data, "R8 data frozen", data_rdata, prev_data);
        end
        while (k < tot - 1) begin
            @(negedge clk);
            k++;
        end
        // R2 / R9: still busy one cycle before the end, even after a repeated start
        check(ctrl_rdata[0] == 1'b1, poke ? "R9 busy not extended" : "R2 busy held",
              ctrl_rdata[0], 1);
        if (!wr)
            // R7: data not updated before busy clears
            check(data_rdata == prev_data, "R7 data timing", data_rdata, prev_data);
        @(negedge clk);
        check(ctrl_rdata[0] == 1'b0, poke ? "R9 busy cleared on time" : "R2 busy cleared",
              ctrl_rdata[0], 0);
        exp_data = wr ? d : phy_word;
        check(data_rdata == exp_data, wr ? "R8 data kept" : "R7 read data",
              data_rdata, exp_data);
        check(ctrl_rdata == ctrl_word(1'b0, wr, cs, ra, phy), "R8 ctrl kept",
              ctrl_rdata, ctrl_word(1'b0, wr, cs, ra, phy));
        // R3: MDC edge count and period
        check(rise_cnt == 64, "R3 rise count", rise_cnt, 64);
        check(bad_period == 0, "R3 period", bad_period, 0);
        // R5 / R6: frame bits and output enables
        ef = exp_frame(wr, phy, ra, d);
        miss = 0;
        for (int i = 0; i < 64; i++) begin
            bit oe_e;
            oe_e = wr || (i < 46);
            if (cap_oe[i] !== oe_e) miss++;
            else if (oe_e && cap_out[i] !== ef[63 - i]) miss++;
        end
        check(miss == 0, wr ? "R5 write frame" : "R6 read frame", miss, 0);
        // R10: MDIO stable through every MDC high phase
        check(hold_viol == 0, "R10 mdio hold", hold_viol, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ctrl_rdata == 16'h0 && data_rdata == 16'h0, "R1 regs", ctrl_rdata, 0);
        check(!mdc && !mdio_oe, "R1 mdc/oe", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Directed: every clock-range code, both directions, extreme values
        run_frame(1'b1, 5'h1F, 5'h00, 2'd2, 16'hA55A, 1'b0);
        run_frame(1'b0, 5'h00, 5'h1F, 2'd2, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h01, 5'h10, 2'd3, 16'h0000, 1'b1);
        run_frame(1'b0, 5'h15, 5'h0A, 2'd0, 16'h8001, 1'b1);
        run_frame(1'b1, 5'h0A, 5'h15, 2'd1, 16'h1234, 1'b0);
        run_frame(1'b0, 5'h1E, 5'h01, 2'd1, 16'h7FFE, 1'b1);
        // Random frames
        for (int t = 0; t < 8; t++) begin
            run_frame(1'($urandom), 5'($urandom), 5'($urandom), 2'($urandom),
                      16'($urandom), 1'($urandom));
        end
        // R4: idle MDC and output enable throughout
        check(idle_viol == 0, "R4 idle", idle_viol, 0);
        check(!mdc && !mdio_oe, "R4 idle end", {mdc, mdio_oe}, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule